// File: doc/BRIEF.md
# DS3 Overhead Error Injector

This block sits in a DS3 transmit path after the overhead generator. It corrupts chosen overhead bits on purpose, so that a far-end receiver's framing and parity monitors can be tested. It receives a serial bit stream together with per-bit markers for five positions: frame start, subframe start, subframe-alignment bit, multiframe-alignment bit and parity bit. It emits the same stream and markers one register stage later, with some of the marked bits inverted.

There are two error engines: one for framing errors and one for parity errors. The framing engine offers four kinds of error. Two of them invert a single bit. The other two are multi-bit kinds, where one request produces a burst spread over a whole subframe or over two frames. Each engine has its own enable and its own single/continuous choice. In single mode, a request arms the engine once. A request comes either from a per-engine register strobe or from one shared manual input pin, chosen by a selector.

Top module: `ds3_err_inject`

## Requirements
- R1: `data_out` and the five marker outputs equal `data_in` and the marker inputs of the previous clock cycle. When no error is selected, `data_out` equals the delayed `data_in` exactly.
- R2: With `fe_kind`=0 (single F), one accepted request inverts exactly one bit: the first bit marked by `fpos_in` in a later cycle than the request.
- R3: With `fe_kind`=1 (single M), one accepted request inverts exactly one bit: the first bit marked by `mpos_in` in a later cycle than the request.
- R4: With `fe_kind`=2 (subframe burst), one accepted request inverts every `fpos_in` bit of the first subframe whose `sosf_in` comes after the request: `F_PER_SF` bits, default 4.
- R5: With `fe_kind`=3 (multiframe burst), one accepted request inverts the first `mpos_in` bit after the request, and then the first `mpos_in` bit of each of the following frames, `OOMF_FRAMES` bits in all (default 2).
- R6: A single parity request inverts every `ppos_in` bit of the first frame whose `sof_in` comes after the request: `P_PER_FRAME` bits, default 2.
- R7: In continuous mode no request is needed. The framing engine inverts every `fpos_in` bit (kinds 0 and 2) or every `mpos_in` bit (kinds 1 and 3). The parity engine inverts every `ppos_in` bit.
- R8: An engine whose enable is low inverts nothing and drops requests, whatever its mode.
- R9: `src_sel`=0 takes requests from `fe_strobe`/`pe_strobe` and ignores `man_req`. `src_sel`=1 takes requests from rising edges of `man_req`, which arm both engines in the same cycle, and ignores the strobes.
- R10: `man_req` is edge-detected. A level held high for many cycles is a single request.
- R11: A request that arrives while an engine is still waiting for its opportunity or running a burst is ignored.
- R12: While `rst_n` is low, `data_out` and all marker outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_in | input | 1 | Incoming DS3 bit |
| sof_in | input | 1 | Marks the first bit of a frame |
| sosf_in | input | 1 | Marks the first bit of a subframe |
| fpos_in | input | 1 | Marks a subframe-alignment bit |
| mpos_in | input | 1 | Marks a multiframe-alignment bit |
| ppos_in | input | 1 | Marks a parity bit |
| fe_en | input | 1 | Framing engine enable |
| fe_kind | input | 2 | 0 single F, 1 single M, 2 subframe burst, 3 multiframe burst |
| fe_cont | input | 1 | Framing engine continuous mode |
| pe_en | input | 1 | Parity engine enable |
| pe_cont | input | 1 | Parity engine continuous mode |
| src_sel | input | 1 | Request source: 0 strobes, 1 manual pin |
| fe_strobe | input | 1 | Framing request strobe |
| pe_strobe | input | 1 | Parity request strobe |
| man_req | input | 1 | Manual request pin, shared by both engines |
| data_out | output | 1 | Delayed, possibly corrupted bit |
| sof_out | output | 1 | Delayed frame-start marker |
| sosf_out | output | 1 | Delayed subframe-start marker |
| fpos_out | output | 1 | Delayed subframe-alignment marker |
| mpos_out | output | 1 | Delayed multiframe-alignment marker |
| ppos_out | output | 1 | Delayed parity marker |

## Verification
A single rising edge on the manual pin arms the framing engine and the parity engine in the same clock cycle. This is the one place where the two functions start together, so each engine must take the request without disturbing the other. The bench provokes it by raising `man_req` once, with a single-F error and a single parity error both enabled. In the same run it also pulses the ignored strobes. The scoreboard then requires the F-bit inversion in the current frame and both parity inversions in the next frame, with every other bit of the stream unchanged.

// File: rtl/ds3ei_pkg.sv
package ds3ei_pkg;

   typedef enum logic [1:0] {
      FK_FBIT = 2'd0,
      FK_MBIT = 2'd1,
      FK_SEF  = 2'd2,
      FK_OOMF = 2'd3
   } fe_kind_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_RUN  = 2'd2
   } eng_st_t;

endpackage

// File: rtl/ds3ei_req_src.sv
module ds3ei_req_src #(
   parameter bit MAN_EDGE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic src_sel,
   input  logic fe_strobe,
   input  logic pe_strobe,
   input  logic man_req,
   output logic fe_req,
   output logic pe_req
);

   logic man_hit;

   generate
      if (MAN_EDGE) begin : g_edge
         logic man_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) man_q <= 1'b0;
            else        man_q <= man_req;
         end
         assign man_hit = man_req & ~man_q;

         AST_MAN_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
            man_hit |=> !man_hit) else $error("manual pulse longer than one cycle"); // R10
      end else begin : g_level
         assign man_hit = man_req;
      end
   endgenerate

   assign fe_req = src_sel ? man_hit : fe_strobe;
   assign pe_req = src_sel ? man_hit : pe_strobe;

   AST_SHARED_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      src_sel |-> (fe_req == pe_req)) else $error("manual request not shared"); // R9

endmodule

// File: rtl/ds3ei_frm_engine.sv
module ds3ei_frm_engine
   import ds3ei_pkg::*;
#(
   parameter int F_PER_SF    = 4,
   parameter int OOMF_FRAMES = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     en,
   input  logic     cont,
   input  fe_kind_t kind,
   input  logic     req,
   input  logic     sof,
   input  logic     sosf,
   input  logic     fpos,
   input  logic     mpos,
   output logic     inv
);

   localparam int CNT_MAX = (F_PER_SF > OOMF_FRAMES) ? F_PER_SF : OOMF_FRAMES;
   localparam int CW      = $clog2(CNT_MAX + 1);

   eng_st_t       st, st_n;
   logic [CW-1:0] cnt, cnt_n;
   logic          blk, blk_n;
   logic          on_f, pos;

   assign on_f = (kind == FK_FBIT) || (kind == FK_SEF);
   assign pos  = on_f ? fpos : mpos;

   always_comb begin
      st_n  = st;
      cnt_n = cnt;
      blk_n = blk;
      inv   = 1'b0;
      if (!en) begin
         st_n = ST_IDLE;
      end else if (cont) begin
         inv  = pos;
         st_n = ST_IDLE;
      end else begin
         case (st)
            ST_IDLE: if (req) st_n = ST_WAIT;
            ST_WAIT: begin
               case (kind)
                  FK_FBIT, FK_MBIT: if (pos) begin
                     inv  = 1'b1;
                     st_n = ST_IDLE;
                  end
                  FK_SEF: if (sosf) begin
                     cnt_n = '0;
                     st_n  = ST_RUN;
                  end
                  default: if (mpos) begin
                     inv   = 1'b1;
                     cnt_n = CW'(1);
                     blk_n = 1'b1;
                     st_n  = (OOMF_FRAMES == 1) ? ST_IDLE : ST_RUN;
                  end
               endcase
            end
            ST_RUN: begin
               if (sof) blk_n = 1'b0;
               case (kind)
                  FK_SEF: if (fpos) begin
                     inv   = 1'b1;
                     cnt_n = cnt + CW'(1);
                     if (cnt_n == CW'(F_PER_SF)) st_n = ST_IDLE;
                  end
                  FK_OOMF: if (mpos && !blk) begin
                     inv   = 1'b1;
                     cnt_n = cnt + CW'(1);
                     blk_n = 1'b1;
                     if (cnt_n == CW'(OOMF_FRAMES)) st_n = ST_IDLE;
                  end
                  default: st_n = ST_IDLE;
               endcase
            end
            default: st_n = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= ST_IDLE;
         cnt <= '0;
         blk <= 1'b0;
      end else begin
         st  <= st_n;
         cnt <= cnt_n;
         blk <= blk_n;
      end
   end

   AST_FE_AT_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      inv |-> (fpos || mpos)) else $error("framing flip off a framing bit"); // R2
   AST_FE_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(CNT_MAX)) else $error("burst counter overran"); // R4
   AST_FE_CONT_EVERY: assert property (@(posedge clk) disable iff (!rst_n)
      (en && cont && kind == FK_FBIT && fpos) |-> inv) else $error("continuous F missed"); // R7
   AST_FE_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WAIT && en && !cont && kind == FK_SEF && !sosf) |=> st == ST_WAIT)
      else $error("armed engine dropped its request"); // R11

endmodule

// File: rtl/ds3ei_par_engine.sv
module ds3ei_par_engine
   import ds3ei_pkg::*;
#(
   parameter int P_PER_FRAME = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic cont,
   input  logic req,
   input  logic sof,
   input  logic ppos,
   output logic inv
);

   localparam int CW = $clog2(P_PER_FRAME + 1);

   eng_st_t       st, st_n;
   logic [CW-1:0] cnt, cnt_n;

   always_comb begin
      st_n  = st;
      cnt_n = cnt;
      inv   = 1'b0;
      if (!en) begin
         st_n = ST_IDLE;
      end else if (cont) begin
         inv  = ppos;
         st_n = ST_IDLE;
      end else begin
         case (st)
            ST_IDLE: if (req) st_n = ST_WAIT;
            ST_WAIT: if (sof) begin
               cnt_n = '0;
               st_n  = ST_RUN;
            end
            ST_RUN: if (ppos) begin
               inv   = 1'b1;
               cnt_n = cnt + CW'(1);
               if (cnt_n == CW'(P_PER_FRAME)) st_n = ST_IDLE;
            end
            default: st_n = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= ST_IDLE;
         cnt <= '0;
      end else begin
         st  <= st_n;
         cnt <= cnt_n;
      end
   end

   AST_PE_AT_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      inv |-> ppos) else $error("parity flip off a parity bit"); // R6
   AST_PE_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(P_PER_FRAME)) else $error("parity counter overran"); // R6
   AST_PE_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (st == ST_IDLE)) else $error("disabled engine kept state"); // R8

endmodule

// File: rtl/ds3_err_inject.sv
module ds3_err_inject
   import ds3ei_pkg::*;
#(
   parameter int F_PER_SF    = 4,
   parameter int OOMF_FRAMES = 2,
   parameter int P_PER_FRAME = 2,
   parameter bit MAN_EDGE    = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       data_in,
   input  logic       sof_in,
   input  logic       sosf_in,
   input  logic       fpos_in,
   input  logic       mpos_in,
   input  logic       ppos_in,
   input  logic       fe_en,
   input  logic [1:0] fe_kind,
   input  logic       fe_cont,
   input  logic       pe_en,
   input  logic       pe_cont,
   input  logic       src_sel,
   input  logic       fe_strobe,
   input  logic       pe_strobe,
   input  logic       man_req,
   output logic       data_out,
   output logic       sof_out,
   output logic       sosf_out,
   output logic       fpos_out,
   output logic       mpos_out,
   output logic       ppos_out
);

   generate
      if (F_PER_SF < 1) begin : g_bad_f
         $error("F_PER_SF must be at least 1");
      end
      if (OOMF_FRAMES < 1) begin : g_bad_m
         $error("OOMF_FRAMES must be at least 1");
      end
      if (P_PER_FRAME < 1) begin : g_bad_p
         $error("P_PER_FRAME must be at least 1");
      end
   endgenerate

   logic fe_req, pe_req, fe_inv, pe_inv;

   ds3ei_req_src #(.MAN_EDGE(MAN_EDGE)) u_src (
      .clk(clk), .rst_n(rst_n), .src_sel(src_sel),
      .fe_strobe(fe_strobe), .pe_strobe(pe_strobe), .man_req(man_req),
      .fe_req(fe_req), .pe_req(pe_req)
   );

   ds3ei_frm_engine #(.F_PER_SF(F_PER_SF), .OOMF_FRAMES(OOMF_FRAMES)) u_frm (
      .clk(clk), .rst_n(rst_n), .en(fe_en), .cont(fe_cont),
      .kind(fe_kind_t'(fe_kind)), .req(fe_req),
      .sof(sof_in), .sosf(sosf_in), .fpos(fpos_in), .mpos(mpos_in),
      .inv(fe_inv)
   );

   ds3ei_par_engine #(.P_PER_FRAME(P_PER_FRAME)) u_par (
      .clk(clk), .rst_n(rst_n), .en(pe_en), .cont(pe_cont), .req(pe_req),
      .sof(sof_in), .ppos(ppos_in), .inv(pe_inv)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_out <= 1'b0;
         sof_out  <= 1'b0;
         sosf_out <= 1'b0;
         fpos_out <= 1'b0;
         mpos_out <= 1'b0;
         ppos_out <= 1'b0;
      end else begin
         data_out <= data_in ^ (fe_inv | pe_inv);
         sof_out  <= sof_in;
         sosf_out <= sosf_in;
         fpos_out <= fpos_in;
         mpos_out <= mpos_in;
         ppos_out <= ppos_in;
      end
   end

   AST_FLIP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && data_out != $past(data_in)) |-> $past(fe_inv || pe_inv))
      else $error("output bit changed with no engine flip"); // R1
   AST_FLIP_ON_OVERHEAD: assert property (@(posedge clk) disable iff (!rst_n)
      (fe_inv || pe_inv) |-> (fpos_in || mpos_in || ppos_in))
      else $error("flip requested on a payload bit"); // R1

endmodule

// File: tb/ds3_err_inject_bench.sv
module ds3_err_inject_bench;

   localparam int FRB = 224;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n, data_in, sof_in, sosf_in, fpos_in, mpos_in, ppos_in;
   logic fe_en, fe_cont, pe_en, pe_cont, src_sel, fe_strobe, pe_strobe, man_req;
   logic [1:0] fe_kind;
   logic data_out, sof_out, sosf_out, fpos_out, mpos_out, ppos_out;

   ds3_err_inject u_ds3_err_inject (
      .clk(clk), .rst_n(rst_n), .data_in(data_in),
      .sof_in(sof_in), .sosf_in(sosf_in), .fpos_in(fpos_in), .mpos_in(mpos_in), .ppos_in(ppos_in),
      .fe_en(fe_en), .fe_kind(fe_kind), .fe_cont(fe_cont), .pe_en(pe_en), .pe_cont(pe_cont),
      .src_sel(src_sel), .fe_strobe(fe_strobe), .pe_strobe(pe_strobe), .man_req(man_req),
      .data_out(data_out), .sof_out(sof_out), .sosf_out(sosf_out),
      .fpos_out(fpos_out), .mpos_out(mpos_out), .ppos_out(ppos_out)
   );

   typedef struct {
      int         idx;
      logic       d;
      logic [4:0] mk;
      string      tag;
   } exp_t;

   exp_t  q[$];
   int    total = 0;
   int    bad   = 0;
   bit    inv_set[int];
   int    fe_at, fe_at2, pe_at, man_from, man_to;
   string cur_tag;

   // Miniature frame: 7 subframes of 8 blocks of 4 bits. Block 0 carries the
   // X/P/M bit (X in subframes 0-1, P in 2-3, M in 4-6); odd blocks carry F bits.
   function automatic logic [4:0] marks(int n);
      int sf, blk;
      bit first;
      sf    = (n % FRB) / 32;
      blk   = (n % 32) / 4;
      first = (n % 4) == 0;
      return {(n % FRB) == 0, (n % 32) == 0,
              first && blk[0],
              first && blk == 0 && sf >= 4,
              first && blk == 0 && (sf == 2 || sf == 3)};
   endfunction

   task automatic clear_all();
      data_in = 0; {sof_in, sosf_in, fpos_in, mpos_in, ppos_in} = '0;
      fe_en = 0; fe_kind = 0; fe_cont = 0; pe_en = 0; pe_cont = 0; src_sel = 0;
      fe_strobe = 0; pe_strobe = 0; man_req = 0;
      fe_at = -1; fe_at2 = -1; pe_at = -1; man_from = -1; man_to = -2;
      inv_set.delete();
   endtask

   task automatic run(int nbits);
      for (int n = 0; n < nbits; n++) begin
         logic       d;
         logic [4:0] mk;
         exp_t       e;
         @(negedge clk);
         d  = 1'($urandom);
         mk = marks(n);
         data_in = d;
         {sof_in, sosf_in, fpos_in, mpos_in, ppos_in} = mk;
         fe_strobe = (n == fe_at) || (n == fe_at2);
         pe_strobe = (n == pe_at);
         man_req   = (n >= man_from) && (n <= man_to);
         e.idx = n;
         e.d   = d ^ inv_set.exists(n);
         e.mk  = mk;
         e.tag = cur_tag;
         q.push_back(e);
      end
      @(negedge clk);
      clear_all();
      repeat (3) @(negedge clk);
   endtask

   // monitor: one result per driven bit, one cycle after it was driven
   initial begin
      forever begin
         exp_t e;
         @(posedge clk);
         #1;
         if (q.size() > 0) begin
            e = q.pop_front();
            total++;
            if (data_out !== e.d ||
                {sof_out, sosf_out, fpos_out, mpos_out, ppos_out} !== e.mk) begin
               bad++;
               $display("FAIL %s bit %0d: actual d=%b mk=%b expected d=%b mk=%b", e.tag, e.idx,
                        data_out, {sof_out, sosf_out, fpos_out, mpos_out, ppos_out}, e.d, e.mk);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: actual running expected finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      clear_all();
      rst_n = 0;
      data_in = 1; {sof_in, sosf_in, fpos_in, mpos_in, ppos_in} = '1;
      repeat (4) @(negedge clk);
      total++;
      if ({data_out, sof_out, sosf_out, fpos_out, mpos_out, ppos_out} !== 6'b0) begin
         bad++;
         $display("FAIL R12 reset: actual %b expected 000000",
                  {data_out, sof_out, sosf_out, fpos_out, mpos_out, ppos_out});
      end
      clear_all();
      @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1: plain delay, no errors
      cur_tag = "R1"; run(FRB);

      // R2 single F by strobe; R9 manual pulse ignored in strobe mode
      cur_tag = "R2/R9"; fe_en = 1; fe_kind = 0; fe_at = 10; man_from = 100; man_to = 101;
      inv_set[12] = 1; run(FRB);

      // R3 single M from manual pin
      cur_tag = "R3"; fe_en = 1; fe_kind = 1; src_sel = 1; man_from = 5; man_to = 8;
      inv_set[128] = 1; run(FRB);

      // R4 subframe burst; R11 second request mid-burst ignored
      cur_tag = "R4/R11"; fe_en = 1; fe_kind = 2; fe_at = 40; fe_at2 = 70;
      inv_set[68] = 1; inv_set[76] = 1; inv_set[84] = 1; inv_set[92] = 1; run(FRB);

      // R5 multiframe burst across two frames
      cur_tag = "R5"; fe_en = 1; fe_kind = 3; fe_at = 140;
      inv_set[160] = 1; inv_set[FRB + 128] = 1; run(2 * FRB);

      // R6 single parity error in next frame
      cur_tag = "R6"; pe_en = 1; pe_at = 70;
      inv_set[FRB + 64] = 1; inv_set[FRB + 96] = 1; run(2 * FRB);

      // R7 continuous F bits and continuous parity
      cur_tag = "R7"; fe_en = 1; fe_kind = 0; fe_cont = 1; pe_en = 1; pe_cont = 1;
      for (int s = 0; s < 7; s++) begin
         for (int k = 0; k < 4; k++) inv_set[s * 32 + 4 + 8 * k] = 1;
      end
      inv_set[64] = 1; inv_set[96] = 1; run(FRB);

      // R7 continuous multiframe kind hits every M bit
      cur_tag = "R7m"; fe_en = 1; fe_kind = 3; fe_cont = 1;
      inv_set[128] = 1; inv_set[160] = 1; inv_set[192] = 1; run(FRB);

      // R8 disabled engines ignore requests and continuous mode
      cur_tag = "R8"; fe_cont = 1; pe_cont = 1; fe_at = 10; pe_at = 10; run(FRB);

      // R9 one manual edge arms both engines; strobes ignored in manual mode
      cur_tag = "R9"; src_sel = 1; fe_en = 1; fe_kind = 0; pe_en = 1;
      fe_at = 5; pe_at = 5; man_from = 20; man_to = 20;
      inv_set[28] = 1; inv_set[FRB + 64] = 1; inv_set[FRB + 96] = 1; run(2 * FRB);

      // R10 held manual level is a single request
      cur_tag = "R10"; src_sel = 1; fe_en = 1; fe_kind = 0; man_from = 3; man_to = 400;
      inv_set[4] = 1; run(2 * FRB);

      repeat (3) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule